// File: doc/BRIEF.md
# Word-Parallel Oversampled Bit Recovery

This block recovers serial data from a line that is sampled eight times per bit period. The samples do not arrive one per fast clock. Each system clock delivers one 8-bit word holding eight samples spaced one eighth of a clock apart, and the system clock runs at the nominal bit rate. Bit k of the word is slot k, and slot 0 is the earliest in time. The block keeps the last sample of the previous word and looks for transitions across the nine-sample span. It reduces each word to a short code: a 2-bit pattern kind plus a 3-bit edge slot.

A two-state machine tracks where the bit boundary falls inside the word.
- **HUNT** waits for a usable edge. The **acquire** transition loads the phase and moves to TRACK.
- **TRACK** has three ways of staying in TRACK:
  - **hold**: the edge is where it was expected.
  - **nudge**: the edge is one slot early or late.
  - **wrap**: a nudge that carries the bit centre across the word boundary.
- Two transitions return TRACK to HUNT:
  - **slip**: the edge is two or more slots away from the phase.
  - **reject**: the word holds an illegal pattern.

Because the far end's clock drifts, one word can contain zero, one or two bit centres. The output therefore carries a 0-to-2 bit count, a valid flag and an error flag.

Top module: `mphase_bit_recovery`

## Requirements
- R1: While reset is asserted, every output is 0. On release the machine is in HUNT with phase 0 and a stored previous sample of 0.
- R2: The transitions are counted across {previous slot 7, slot 0..7}. The word is classified as follows:
  - 0 transitions: flat.
  - 1 transition: step, with the edge at the slot that differs from its predecessor.
  - Exactly 2 transitions, at slots 0 and 7: pulse.
  - Anything else: illegal, and code_err is 1 in that word's output cycle.
- R3: In HUNT, a flat word gives no bits. A step or pulse word loads the phase with the edge slot, enters TRACK and gives no bits.
- R4: In TRACK with no phase change, exactly one bit is output: the sample at slot (phase+4) mod 8, in bits_out[0], with bits_cnt=1.
- R5: In TRACK, an edge one slot after or one slot before the phase (modulo 8) replaces the phase with the edge slot. The bit is taken at the new centre.
- R6: When a nudge moves the centre from slot 7 to slot 0, the cycle outputs no bits.
- R7: When a nudge moves the centre from slot 0 to slot 7, two bits are output. bits_out[1] is slot 7 of the previous word (earlier in time) and bits_out[0] is slot 7 of the current word, with bits_cnt=2.
- R8: In TRACK, an edge two or more slots from the phase raises code_err, outputs no bits and returns to HUNT.
- R9: In TRACK, an illegal word raises code_err, outputs no bits and returns to HUNT, so the following cycle outputs no bits.
- R10: bits_vld is 1 exactly when bits_cnt is nonzero. bits_cnt never equals 3, and every bits_out bit beyond the count is 0.
- R11: The outputs for a word appear after the first rising clock edge that samples it, and hold for one cycle.
- R12: A pulse word uses slot 7 as its edge slot, both for acquisition and for phase comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one word per bit period |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_word | input | 8 | Registered line samples, bit k = slot k, slot 0 earliest |
| bits_out | output | 2 | Recovered bits, earlier bit in bit 1 when two are valid |
| bits_cnt | output | 2 | Number of valid recovered bits (0, 1 or 2) |
| bits_vld | output | 1 | At least one recovered bit this cycle |
| code_err | output | 1 | Illegal pattern or phase slip in the word |

## Verification
All results of a word are registered once. Count, bits and error flag are due one rising edge after the word is driven, so the bench changes the word on a falling edge and reads the outputs at the next falling edge, just before it drives the following word. The effect of the stored previous sample needs one more word. The two-bit order and the return to HUNT are checked on the word after the one that set them up, and each table row is written with the previous word's slot 7 in mind. The effect of reset is read while reset is held, because it clears the outputs without a clock.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    // compressed description of one sample word
    typedef enum logic [1:0] {
        PAT_FLAT  = 2'd0,
        PAT_STEP  = 2'd1,
        PAT_PULSE = 2'd2,
        PAT_BAD   = 2'd3
    } pat_kind_e;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_e;

endpackage

// File: rtl/mbr_edge_classify.sv
module mbr_edge_classify
    import mbr_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] word_i,
    input  logic             prev_i,
    output pat_kind_e        kind_o,
    output logic [SW-1:0]    slot_o
);

    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    logic [SLOTS-1:0] trans;

    // transition into each slot from its predecessor
    assign trans[0] = word_i[0] ^ prev_i;
    for (genvar k = 1; k < SLOTS; k++) begin : g_trans
        assign trans[k] = word_i[k] ^ word_i[k-1];
    end

    logic [SW-1:0] first_edge;
    int            n_edges;

    always_comb begin
        first_edge = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (trans[k]) first_edge = SW'(k);
        end
        n_edges = $countones(trans);
    end

    always_comb begin
        kind_o = PAT_BAD;
        slot_o = '0;
        if (n_edges == 0) begin
            kind_o = PAT_FLAT;
        end else if (n_edges == 1) begin
            kind_o = PAT_STEP;
            slot_o = first_edge;
        end else if (n_edges == 2 && trans[0] && trans[SLOTS-1]) begin
            // short cell wholly inside the word; the later edge sets phase
            kind_o = PAT_PULSE;
            slot_o = LAST;
        end
    end

endmodule

// File: rtl/mbr_phase_track.sv
module mbr_phase_track
    import mbr_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] word_i,
    input  logic             prev_i,
    input  pat_kind_e        kind_i,
    input  logic [SW-1:0]    slot_i,
    output logic [1:0]       bits_o,
    output logic [1:0]       cnt_o,
    output logic             vld_o,
    output logic             err_o
);

    localparam logic [SW-1:0] HALF = SW'(SLOTS / 2);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);
    localparam logic [SW-1:0] ONE  = SW'(1);

    trk_state_e    state_q, state_d;
    logic [SW-1:0] phase_q, phase_d;

    logic [SW-1:0] offset;
    logic [SW-1:0] ctr_old, ctr_new;
    logic          emit;
    logic [1:0]    bits_d, cnt_d;
    logic          err_d;

    assign offset  = slot_i - phase_q;
    assign ctr_old = phase_q + HALF;
    assign ctr_new = phase_d + HALF;

    // next state and phase
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        emit    = 1'b0;
        err_d   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                unique case (kind_i)
                    PAT_STEP, PAT_PULSE: begin   // acquire
                        phase_d = slot_i;
                        state_d = ST_TRACK;
                    end
                    PAT_BAD:  err_d = 1'b1;
                    PAT_FLAT: ;
                endcase
            end
            ST_TRACK: begin
                unique case (kind_i)
                    PAT_FLAT: emit = 1'b1;       // hold
                    PAT_BAD: begin               // reject
                        err_d   = 1'b1;
                        state_d = ST_HUNT;
                    end
                    PAT_STEP, PAT_PULSE: begin
                        if (offset == '0) begin
                            emit = 1'b1;         // hold
                        end else if (offset == ONE || offset == LAST) begin
                            phase_d = slot_i;    // nudge / wrap
                            emit    = 1'b1;
                        end else begin           // slip
                            err_d   = 1'b1;
                            state_d = ST_HUNT;
                        end
                    end
                endcase
            end
        endcase
    end

    // bit selection around the centre slot
    always_comb begin
        bits_d = 2'b00;
        cnt_d  = 2'd0;
        if (emit) begin
            if (ctr_old == LAST && ctr_new == '0) begin
                cnt_d = 2'd0;
            end else if (ctr_old == '0 && ctr_new == LAST) begin
                cnt_d  = 2'd2;
                bits_d = {prev_i, word_i[SLOTS-1]};
            end else begin
                cnt_d  = 2'd1;
                bits_d = {1'b0, word_i[ctr_new]};
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_o <= 2'b00;
            cnt_o  <= 2'd0;
            vld_o  <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            bits_o <= bits_d;
            cnt_o  <= cnt_d;
            vld_o  <= (cnt_d != 2'd0);
            err_o  <= err_d;
        end
    end

endmodule

// File: rtl/mphase_bit_recovery.sv
module mphase_bit_recovery
    import mbr_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] smp_word,
    output logic [1:0]       bits_out,
    output logic [1:0]       bits_cnt,
    output logic             bits_vld,
    output logic             code_err
);

    localparam int SW = $clog2(SLOTS);

    logic          last_smp_q;
    pat_kind_e     kind;
    logic [SW-1:0] slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_smp_q <= 1'b0;
        else        last_smp_q <= smp_word[SLOTS-1];
    end

    mbr_edge_classify #(.SLOTS(SLOTS)) classify_i (
        .word_i (smp_word),
        .prev_i (last_smp_q),
        .kind_o (kind),
        .slot_o (slot)
    );

    mbr_phase_track #(.SLOTS(SLOTS)) track_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (smp_word),
        .prev_i (last_smp_q),
        .kind_i (kind),
        .slot_i (slot),
        .bits_o (bits_out),
        .cnt_o  (bits_cnt),
        .vld_o  (bits_vld),
        .err_o  (code_err)
    );

endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
    parameter int SLOTS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SLOTS-1:0] smp_word,
    input logic [1:0]       bits_out,
    input logic [1:0]       bits_cnt,
    input logic             bits_vld,
    input logic             code_err
);

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bits_cnt != 2'd3); // R10

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bits_vld |-> (bits_out == 2'b00 && bits_cnt == 2'd0)); // R10

    AST_SINGLE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bits_cnt == 2'd1 |-> !bits_out[1]); // R10

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> bits_cnt == 2'd0); // R9

    AST_ERR_THEN_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |=> !bits_vld); // R8

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        bits_cnt == 2'd2 |->
            bits_out == {$past(smp_word[SLOTS-1], 2), $past(smp_word[SLOTS-1])}); // R7

endmodule

bind mphase_bit_recovery mbr_checker #(.SLOTS(SLOTS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_word (smp_word),
    .bits_out (bits_out),
    .bits_cnt (bits_cnt),
    .bits_vld (bits_vld),
    .code_err (code_err)
);

// File: tb/mphase_bit_recovery_tb_top.sv
module mphase_bit_recovery_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] smp_word = 8'h00;
    logic [1:0] bits_out;
    logic [1:0] bits_cnt;
    logic       bits_vld;
    logic       code_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mphase_bit_recovery #(.SLOTS(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_word (smp_word),
        .bits_out (bits_out),
        .bits_cnt (bits_cnt),
        .bits_vld (bits_vld),
        .code_err (code_err)
    );

    // {word, expected count, expected bits, expected error}
    localparam int NV = 20;
    localparam logic [12:0] VEC [NV] = '{
        {8'h00, 2'd0, 2'b00, 1'b0},  // hunt, flat
        {8'hFC, 2'd0, 2'b00, 1'b0},  // acquire at slot 2
        {8'hFF, 2'd1, 2'b01, 1'b0},  // centre 6
        {8'h03, 2'd1, 2'b00, 1'b0},  // edge on phase
        {8'h00, 2'd1, 2'b00, 1'b0},
        {8'hF8, 2'd1, 2'b01, 1'b0},  // late nudge 2->3
        {8'h0F, 2'd0, 2'b00, 1'b0},  // late nudge, centre 7->0
        {8'hF0, 2'd1, 2'b00, 1'b0},  // centre 0
        {8'h07, 2'd2, 2'b10, 1'b0},  // early nudge, centre 0->7
        {8'h00, 2'd1, 2'b00, 1'b0},
        {8'hC0, 2'd0, 2'b00, 1'b1},  // slip by 3
        {8'hFF, 2'd0, 2'b00, 1'b0},  // hunt, flat
        {8'h00, 2'd0, 2'b00, 1'b0},  // acquire at slot 0
        {8'h7F, 2'd1, 2'b01, 1'b0},  // pulse, phase 0->7
        {8'h00, 2'd1, 2'b00, 1'b0},
        {8'hFF, 2'd1, 2'b01, 1'b0},  // late nudge 7->0
        {8'h80, 2'd1, 2'b00, 1'b0},  // inverted pulse, phase 0->7
        {8'h33, 2'd0, 2'b00, 1'b1},  // illegal in track
        {8'h00, 2'd0, 2'b00, 1'b0},  // hunt
        {8'h81, 2'd0, 2'b00, 1'b1}   // illegal in hunt
    };

    function automatic string row_tag(int i);
        case (i)
            0, 1, 11, 12, 18: return "R3";
            2, 3, 4, 7, 9, 14: return "R4";
            5, 15:            return "R5";
            6:                return "R6";
            8:                return "R7";
            10:               return "R8";
            13, 16:           return "R12";
            17:               return "R9";
            default:          return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input logic [1:0] ecnt,
                         input logic [1:0] ebits, input logic eerr);
        checks++;
        if (bits_cnt !== ecnt || bits_out !== ebits || code_err !== eerr) begin
            failures++;
            $display("FAIL %s: cnt=%0d bits=%b err=%b expected cnt=%0d bits=%b err=%b",
                     tag, bits_cnt, bits_out, code_err, ecnt, ebits, eerr);
        end
        checks++;
        if (bits_vld !== (ecnt != 2'd0)) begin
            failures++;
            $display("FAIL R10 (%s): vld=%b expected %b", tag, bits_vld, ecnt != 2'd0);
        end
    endtask

    // word changes on a falling edge, results read one falling edge later (R11)
    task automatic apply(input logic [7:0] w);
        smp_word = w;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 2'd0, 2'b00, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][12:5]);
            check($sformatf("%s row %0d R11", row_tag(i), i),
                  VEC[i][4:3], VEC[i][2:1], VEC[i][0]);
        end

        // back into TRACK with valid output, then reset mid-stream
        apply(8'h00);                     // prev 1 -> edge at slot 0, acquire
        check("R3 reacquire", 2'd0, 2'b00, 1'b0);
        apply(8'h00);
        check("R4 one bit before reset", 2'd1, 2'b00, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", 2'd0, 2'b00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'h00);
        check("R1 hunt after reset", 2'd0, 2'b00, 1'b0);

        // pulse acquires at slot 7: edge at slot 1 is then two slots away
        apply(8'h7F);
        check("R12 pulse acquire", 2'd0, 2'b00, 1'b0);
        apply(8'hFE);
        check("R12 slip against slot 7", 2'd0, 2'b00, 1'b1);
        apply(8'hFF);
        check("R8 hunt after slip", 2'd0, 2'b00, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule